// File: doc/BRIEF.md
# Shared-Line Interrupt Link Router

This block steers level-sensitive device interrupts onto a bank of sixteen legacy IRQ lines. Each device is attached to one of eight link pins, or to none. It reports its request as a one-cycle assert event and a one-cycle release event. For each link pin the block counts how many attached devices are currently asserting. While that count is nonzero, the link drives the IRQ line that its routing register selects, provided the route is legal.

Software sees eight 8-bit routing registers through a flat read/write port. Bit 7 of a register disables the link. Bits 3:0 pick the IRQ number. An IRQ number outside the permitted set makes the link behave as if it were disabled.

A register can be rewritten while its link is active. In that case the live level leaves the old line and appears on the new line in the same cycle, so there is no overlap and no gap. Independently of any routing, every device also has a dedicated output that mirrors its own request, intended for a separate interrupt controller input.

Top module: `irq_link_router`

## Requirements
- R1: After reset every routing register reads 0x80, and every `irq_out` and `apic_out` bit is 0.
- R2: A write to `reg_addr` = k (link k+1) stores `reg_wdata & 0x8F`, so bits 6:4 always read 0. `reg_rdata` returns the stored value of the link selected by `reg_addr`, combinationally.
- R3: A route is legal only when bit 7 is 0 and bits 3:0 lie in {3-7, 9-12, 14-15} (mask 0xDEF8). A disabled or illegal route drives no `irq_out` bit, however many devices assert.
- R4: A link's request count rises on each assert event and falls on each release event from devices whose `dev_pin` code is that link's number (1 to 8). The selected line stays high until every sharer has released.
- R5: If a link's register changes while its count is nonzero, the old line (if legal) falls and the new line (if legal) rises in the same cycle.
- R6: Rewriting a register with a value that stores unchanged has no effect on any `irq_out` bit.
- R7: `apic_out[d]` goes high one cycle after an assert event of device d and low one cycle after a release event. This holds whatever the route, and also for a device with `dev_pin` code 0 (attached to no link).
- R8: Each `irq_out` bit is the OR of all active links whose legal route selects that IRQ number.
- R9: The request count stops at 0 on a release event with no matching assert, and stops at 2^CNT_W-1 instead of wrapping; CNT_W is at least 4.
- R10: `irq_out` is registered. An event or write sampled at clock edge k changes `irq_out` after edge k+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Routing register write strobe |
| reg_addr | input | ADDR_W | Link index (0 = link 1) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Stored routing value of the addressed link |
| req_set | input | NUM_DEV | Per-device assert event |
| req_clr | input | NUM_DEV | Per-device release event |
| dev_pin | input | NUM_DEV*SEL_W | Per-device link number, 0 = none |
| irq_out | output | 16 | IRQ lines |
| apic_out | output | NUM_DEV | Dedicated per-device request lines |

## Verification
The bench uses the default eight links and CNT_W = 4, with NUM_DEV = 4. Two devices share link 1, one device sits alone on link 2, and one device is attached to no link. This lets a shared link, two links merging onto one line, and an unrouted device all be exercised together. With a 4-bit counter, the ceiling of 15 sharers can be reached within a few dozen event pulses, so saturation at both ends is checked at the ports.

// File: rtl/irq_rt_pkg.sv
package irq_rt_pkg;
   localparam int ROUTE_W  = 8;
   localparam int IRQ_W    = 4;
   localparam int NUM_IRQ  = 1 << IRQ_W;
   localparam logic [ROUTE_W-1:0] KEEP_MASK = 8'h8F;
   localparam logic [ROUTE_W-1:0] OFF_VALUE = 8'h80;

   function automatic logic route_legal(input logic [ROUTE_W-1:0] r,
                                        input logic [NUM_IRQ-1:0] allow);
      return !r[ROUTE_W-1] && allow[r[IRQ_W-1:0]];
   endfunction
endpackage

// File: rtl/irq_link_slot.sv
module irq_link_slot
   import irq_rt_pkg::*;
#(
   parameter int NUM_DEV = 4,
   parameter int SEL_W   = 4,
   parameter int CNT_W   = 4,
   parameter int LINK_NO = 1,
   parameter logic [NUM_IRQ-1:0] ALLOW_MASK = 16'hDEF8
)(
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr_en,
   input  logic [ROUTE_W-1:0]       wr_data,
   input  logic [NUM_DEV-1:0]       req_set,
   input  logic [NUM_DEV-1:0]       req_clr,
   input  logic [NUM_DEV*SEL_W-1:0] dev_pin,
   output logic [ROUTE_W-1:0]       route,
   output logic                     drive,
   output logic [IRQ_W-1:0]         irq_num
);
   localparam int CNT_MAX = (1 << CNT_W) - 1;

   logic [CNT_W-1:0] cnt_q, cnt_d;

   always_comb begin
      int ups, downs, t;
      ups = 0;
      downs = 0;
      for (int d = 0; d < NUM_DEV; d++) begin
         if (dev_pin[d*SEL_W +: SEL_W] == SEL_W'(LINK_NO)) begin
            if (req_set[d]) ups++;
            if (req_clr[d]) downs++;
         end
      end
      t = int'(cnt_q) + ups - downs;
      if (t < 0) t = 0;
      if (t > CNT_MAX) t = CNT_MAX;
      cnt_d = CNT_W'(t);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
         route <= OFF_VALUE;
      end else begin
         cnt_q <= cnt_d;
         if (wr_en) route <= wr_data & KEEP_MASK;
      end
   end

   assign drive   = (cnt_q != '0) && route_legal(route, ALLOW_MASK);
   assign irq_num = route[IRQ_W-1:0];
endmodule

// File: rtl/irq_line_merge.sv
module irq_line_merge
   import irq_rt_pkg::*;
#(
   parameter int NUM_LINKS = 8
)(
   input  logic [NUM_LINKS-1:0]       drive,
   input  logic [NUM_LINKS*IRQ_W-1:0] irq_num,
   output logic [NUM_IRQ-1:0]         lines
);
   for (genvar i = 0; i < NUM_IRQ; i++) begin : g_line
      logic [NUM_LINKS-1:0] hit;
      for (genvar l = 0; l < NUM_LINKS; l++) begin : g_src
         assign hit[l] = drive[l] && (irq_num[l*IRQ_W +: IRQ_W] == IRQ_W'(i));
      end
      assign lines[i] = |hit;
   end
endmodule

// File: rtl/irq_link_router.sv
module irq_link_router
   import irq_rt_pkg::*;
#(
   parameter int NUM_LINKS = 8,
   parameter int NUM_DEV   = 4,
   parameter int CNT_W     = 4,
   parameter logic [15:0] ALLOW_MASK = 16'hDEF8,
   localparam int ADDR_W = (NUM_LINKS > 1) ? $clog2(NUM_LINKS) : 1,
   localparam int SEL_W  = $clog2(NUM_LINKS + 1)
)(
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     reg_we,
   input  logic [ADDR_W-1:0]        reg_addr,
   input  logic [7:0]               reg_wdata,
   output logic [7:0]               reg_rdata,
   input  logic [NUM_DEV-1:0]       req_set,
   input  logic [NUM_DEV-1:0]       req_clr,
   input  logic [NUM_DEV*SEL_W-1:0] dev_pin,
   output logic [15:0]              irq_out,
   output logic [NUM_DEV-1:0]       apic_out
);
   if (CNT_W < 4) begin : g_bad_cnt
      $error("irq_link_router: CNT_W must be at least 4");
   end
   if (NUM_LINKS < 1 || NUM_DEV < 1) begin : g_bad_size
      $error("irq_link_router: NUM_LINKS and NUM_DEV must be positive");
   end

   logic [ROUTE_W-1:0]       route_arr [NUM_LINKS];
   logic [NUM_LINKS-1:0]     drive;
   logic [NUM_LINKS*IRQ_W-1:0] irq_num;
   logic [NUM_IRQ-1:0]       lines;

   for (genvar l = 0; l < NUM_LINKS; l++) begin : g_link
      irq_link_slot #(
         .NUM_DEV(NUM_DEV), .SEL_W(SEL_W), .CNT_W(CNT_W),
         .LINK_NO(l + 1), .ALLOW_MASK(ALLOW_MASK)
      ) u_slot (
         .clk(clk), .rst_n(rst_n),
         .wr_en(reg_we && (int'(reg_addr) == l)),
         .wr_data(reg_wdata),
         .req_set(req_set), .req_clr(req_clr), .dev_pin(dev_pin),
         .route(route_arr[l]),
         .drive(drive[l]),
         .irq_num(irq_num[l*IRQ_W +: IRQ_W])
      );
   end

   irq_line_merge #(.NUM_LINKS(NUM_LINKS)) u_merge (
      .drive(drive), .irq_num(irq_num), .lines(lines)
   );

   always_comb begin
      reg_rdata = OFF_VALUE;
      for (int l = 0; l < NUM_LINKS; l++)
         if (int'(reg_addr) == l) reg_rdata = route_arr[l];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         irq_out  <= '0;
         apic_out <= '0;
      end else begin
         irq_out  <= lines;
         apic_out <= (apic_out | (req_set & ~req_clr)) & ~(req_clr & ~req_set);
      end
   end
endmodule

// File: rtl/irq_link_router_chk.sv
module irq_link_router_chk #(
   parameter int NUM_DEV = 4,
   parameter logic [15:0] ALLOW_MASK = 16'hDEF8
)(
   input logic               clk,
   input logic               rst_n,
   input logic               reg_we,
   input logic [7:0]         reg_rdata,
   input logic [NUM_DEV-1:0] req_set,
   input logic [NUM_DEV-1:0] req_clr,
   input logic [15:0]        irq_out,
   input logic [NUM_DEV-1:0] apic_out
);
   logic quiet;
   assign quiet = !reg_we && (req_set == '0) && (req_clr == '0);

   a_r1_reset_quiet: assert property (@(posedge clk)
      !rst_n |=> (irq_out == '0) && (apic_out == '0));

   a_r2_read_mask: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rdata & 8'h70) == 8'h00);

   a_r3_only_legal_lines: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_out & ~ALLOW_MASK) == 16'h0000);

   a_r6_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
      quiet |=> ##1 $stable(irq_out));

   for (genvar d = 0; d < NUM_DEV; d++) begin : g_dev
      a_r7_apic_rise: assert property (@(posedge clk) disable iff (!rst_n)
         (req_set[d] && !req_clr[d]) |=> apic_out[d]);
      a_r7_apic_fall: assert property (@(posedge clk) disable iff (!rst_n)
         (req_clr[d] && !req_set[d]) |=> !apic_out[d]);
   end
endmodule

bind irq_link_router irq_link_router_chk #(
   .NUM_DEV(NUM_DEV), .ALLOW_MASK(ALLOW_MASK)
) u_chk (
   .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_rdata(reg_rdata),
   .req_set(req_set), .req_clr(req_clr), .irq_out(irq_out), .apic_out(apic_out)
);

// File: tb/sim_irq_link_router.sv
module sim_irq_link_router;
   localparam int NUM_DEV = 4;
   localparam int SEL_W   = 4;

   logic               clk = 0;
   logic               rst_n = 0;
   logic               reg_we = 0;
   logic [2:0]         reg_addr = '0;
   logic [7:0]         reg_wdata = '0;
   logic [7:0]         reg_rdata;
   logic [NUM_DEV-1:0] req_set = '0;
   logic [NUM_DEV-1:0] req_clr = '0;
   logic [NUM_DEV*SEL_W-1:0] dev_pin = {4'd0, 4'd2, 4'd1, 4'd1};
   logic [15:0]        irq_out;
   logic [NUM_DEV-1:0] apic_out;

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;

   irq_link_router #(.NUM_DEV(NUM_DEV)) u0 (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .req_set(req_set),
      .req_clr(req_clr), .dev_pin(dev_pin), .irq_out(irq_out), .apic_out(apic_out)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input int a, input logic [7:0] d);
      @(negedge clk); reg_we = 1; reg_addr = 3'(a); reg_wdata = d;
      @(negedge clk); reg_we = 0;
   endtask

   task automatic rd(input int a, output logic [7:0] v);
      reg_addr = 3'(a); #1; v = reg_rdata;
   endtask

   task automatic pset(input int d);
      @(negedge clk); req_set[d] = 1;
      @(negedge clk); req_set = '0;
   endtask

   task automatic pclr(input int d);
      @(negedge clk); req_clr[d] = 1;
      @(negedge clk); req_clr = '0;
   endtask

   task automatic settle();
      @(negedge clk);
   endtask

   task automatic t_reset();
      logic [7:0] v;
      for (int a = 0; a < 8; a++) begin
         rd(a, v); chk("R1 reg reset", 32'(v), 32'h80);
      end
      chk("R1 irq reset", 32'(irq_out), 0);
      chk("R1 apic reset", 32'(apic_out), 0);
   endtask

   task automatic t_write_read();
      logic [7:0] v;
      wr(0, 8'hFF); rd(0, v); chk("R2 masked store", 32'(v), 32'h8F);
      wr(7, 8'h3A); rd(7, v); chk("R2 link 8 store", 32'(v), 32'h0A);
      rd(0, v); chk("R2 other link kept", 32'(v), 32'h8F);
      wr(0, 8'h05); rd(0, v); chk("R2 rewrite", 32'(v), 32'h05);
   endtask

   task automatic t_basic();
      pset(0);
      chk("R7 apic rise", 32'(apic_out), 32'h1);
      chk("R10 irq one cycle later", 32'(irq_out), 0);
      settle();
      chk("R4 line driven", 32'(irq_out), 32'h0020);
   endtask

   task automatic t_share();
      pset(1); settle();
      pclr(0); settle();
      chk("R4 sharer holds line", 32'(irq_out), 32'h0020);
      chk("R7 apic fall", 32'(apic_out), 32'h2);
      pclr(1); settle();
      chk("R4 last release drops", 32'(irq_out), 0);
   endtask

   task automatic t_move();
      wr(0, 8'h03); pset(0); settle();
      chk("R5 start on 3", 32'(irq_out), 32'h0008);
      wr(0, 8'h0C);
      chk("R5 old until next edge", 32'(irq_out), 32'h0008);
      settle();
      chk("R5 moved to 12", 32'(irq_out), 32'h1000);
   endtask

   task automatic t_same();
      wr(0, 8'h7C); settle();
      chk("R6 unchanged rewrite", 32'(irq_out), 32'h1000);
      wr(0, 8'h0C); settle();
      chk("R6 identical rewrite", 32'(irq_out), 32'h1000);
   endtask

   task automatic t_invalid();
      wr(0, 8'h08); settle();
      chk("R3 irq 8 illegal", 32'(irq_out), 0);
      wr(0, 8'h0D); settle();
      chk("R3 irq 13 illegal", 32'(irq_out), 0);
      wr(0, 8'h85); settle();
      chk("R3 disabled", 32'(irq_out), 0);
      chk("R7 apic despite route", 32'(apic_out[0]), 1);
      wr(0, 8'h09); settle();
      chk("R5 illegal to legal", 32'(irq_out), 32'h0200);
      wr(0, 8'h0C); settle();
   endtask

   task automatic t_merge();
      wr(1, 8'h0C); pset(2); settle();
      chk("R8 two links one line", 32'(irq_out), 32'h1000);
      pclr(0); settle();
      chk("R8 other link holds", 32'(irq_out), 32'h1000);
      pclr(2); settle();
      chk("R8 both released", 32'(irq_out), 0);
   endtask

   task automatic t_sat();
      pclr(0); pclr(0); pset(0); settle();
      chk("R9 floor at zero", 32'(irq_out), 32'h1000);
      pclr(0); settle();
      chk("R9 single release drops", 32'(irq_out), 0);
      for (int i = 0; i < 16; i++) pset(0);
      settle();
      chk("R9 no wrap at top", 32'(irq_out), 32'h1000);
      for (int i = 0; i < 15; i++) pclr(0);
      settle();
      chk("R9 ceiling 15", 32'(irq_out), 0);
   endtask

   task automatic t_nopin();
      pset(3); settle();
      chk("R7 unattached apic", 32'(apic_out[3]), 1);
      chk("R7 unattached no irq", 32'(irq_out), 0);
      pclr(3);
      chk("R7 unattached apic fall", 32'(apic_out[3]), 0);
   endtask

   initial begin
      #(200000 * 20);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      t_reset();
      t_write_read();
      t_basic();
      t_share();
      t_move();
      t_same();
      t_invalid();
      t_merge();
      t_sat();
      t_nopin();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule